// File: doc/BRIEF.md
# Keyed watchdog timer

This block is a memory-mapped watchdog. It has a 32-bit register port and three registers: control/status, counter/command and timeout. A tick input gives one pulse per millisecond period and advances the counter. When the enabled counter reaches the programmed timeout, the block raises a reset request for one cycle and starts counting again from zero. Software keeps the system alive by writing a refresh key to the counter register.

Writes to the control and timeout registers are locked until an unlock key is written to the counter register. The unlock opens a window of a fixed number of bus-clock cycles. A control bit selects the key format. In one format each key is a single 32-bit write. In the other, each key is a pair of consecutive 16-bit writes. A write to control/status inside the window closes the window and reports that reconfiguration is complete. An update-allowed bit, once cleared, freezes the configuration until the next reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the control register reads 0x000000A0 (enable bit 7 and update-allowed bit 5 set; 32-bit key mode, unlocked and done all clear). The timeout register reads all ones (0x1FFFF at the default width), the counter reads 0 and `rst_req` is low.
- R2: The byte offsets are control 0x0, counter 0x4 and timeout 0x8. Read data is registered and is valid on the cycle after `rd_en`. Control bit 13 is the 32-bit key mode, bit 11 is unlocked (read only), bit 10 is reconfiguration done (read only), bit 7 is enable and bit 5 is update-allowed.
- R3: When bit 13 is set, a single write with `wr_full`=1 of 0xD928C520 to the counter register unlocks the block, and 0xB480A602 refreshes it. 16-bit writes to the counter are then ignored.
- R4: When bit 13 is clear, keys are two consecutive writes with `wr_full`=0, using `wdata[15:0]`. Unlock is 0xC520 then 0xD928; refresh is 0xA602 then 0xB480. Any other write in between breaks the pair. 32-bit key writes are ignored in this mode.
- R5: A write of any other value to the counter register has no effect on the count or the lock state.
- R6: The unlock window accepts control and timeout writes on the UNLOCK_CYC clock edges that follow the unlock write. Such writes outside the window are ignored.
- R7: An accepted control write updates bits 13, 7 and 5, clears the count, closes the window, clears unlocked and sets done. An accepted timeout write updates the timeout and leaves the window open. A new unlock clears done.
- R8: Once update-allowed is cleared, control and timeout writes are ignored, even after a fresh unlock.
- R9: While enabled, each tick raises the count by one, and the count is readable at 0x4. While disabled, the count stays at 0.
- R10: A tick that arrives when the count is at or above the timeout raises `rst_req` for exactly one cycle on the next cycle and returns the count to 0.
- R11: A refresh clears the count. A refresh in the same cycle as an expiring tick wins: no reset request is raised.
- R12: The timeout field is TOV_W bits (default 17), so 128 s at a 1 kHz tick (128000) fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One pulse per timer period |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_full | input | 1 | 1 = 32-bit write, 0 = 16-bit write in wdata[15:0] |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two functions can fall in the same cycle: a refresh key write, and a tick that would expire the count. The bench counts the counter up to the timeout. It then drives the final tick on the same clock as the refresh write and expects `rst_req` to stay low and the counter to read back as zero. A behavioural model in the bench follows the same priority on every clock. Any fire it does not predict is reported.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CNT  = 4'h4;
  localparam logic [3:0] OFF_TOV  = 4'h8;

  localparam logic [31:0] KEY32_UNLOCK  = 32'hD928_C520;
  localparam logic [31:0] KEY32_REFRESH = 32'hB480_A602;
  localparam logic [15:0] KEY16_UNL_A   = 16'hC520;
  localparam logic [15:0] KEY16_UNL_B   = 16'hD928;
  localparam logic [15:0] KEY16_REF_A   = 16'hA602;
  localparam logic [15:0] KEY16_REF_B   = 16'hB480;

  localparam int BIT_MODE32 = 13;
  localparam int BIT_UNLKD  = 11;
  localparam int BIT_DONE   = 10;
  localparam int BIT_EN     = 7;
  localparam int BIT_UPD    = 5;

  typedef enum logic [1:0] {HALF_NONE, HALF_UNL, HALF_REF} half_t;
endpackage

// File: rtl/keyed_wdog_keys.sv
module keyed_wdog_keys
  import keyed_wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        mode32,
  input  logic        wr_en,
  input  logic        wr_full,
  input  logic        hit_cnt,
  input  logic [31:0] wdata,
  output logic        unlock_p,
  output logic        refresh_p
);
  half_t half_q, half_d;
  logic  w32, w16;

  assign w32 = wr_en && hit_cnt && wr_full && mode32;
  assign w16 = wr_en && hit_cnt && !wr_full && !mode32;

  always_comb begin
    unlock_p  = 1'b0;
    refresh_p = 1'b0;
    if (w32) begin
      unlock_p  = (wdata == KEY32_UNLOCK);
      refresh_p = (wdata == KEY32_REFRESH);
    end else if (w16) begin
      unlock_p  = (half_q == HALF_UNL) && (wdata[15:0] == KEY16_UNL_B);
      refresh_p = (half_q == HALF_REF) && (wdata[15:0] == KEY16_REF_B);
    end
  end

  always_comb begin
    half_d = half_q;
    if (mode32) begin
      half_d = HALF_NONE;
    end else if (wr_en) begin
      if (w16 && wdata[15:0] == KEY16_UNL_A)      half_d = HALF_UNL;
      else if (w16 && wdata[15:0] == KEY16_REF_A) half_d = HALF_REF;
      else                                        half_d = HALF_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) half_q <= HALF_NONE;
    else     half_q <= half_d;
  end

  AST_KEY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({unlock_p, refresh_p})); // R3
endmodule

// File: rtl/keyed_wdog_cfg.sv
module keyed_wdog_cfg
  import keyed_wdog_pkg::*;
#(
  parameter int TOV_W      = 17,
  parameter int UNLOCK_CYC = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unlock_p,
  input  logic             wr_en,
  input  logic             hit_ctrl,
  input  logic             hit_tov,
  input  logic [31:0]      wdata,
  output logic             mode32,
  output logic             en,
  output logic             upd,
  output logic             unlocked,
  output logic             done,
  output logic [TOV_W-1:0] tov,
  output logic             ctrl_wr
);
  localparam int WIN_W = $clog2(UNLOCK_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(UNLOCK_CYC);

  logic [WIN_W-1:0] win;
  logic             open_ok, tov_wr;

  assign open_ok = unlocked && upd;
  assign ctrl_wr = wr_en && hit_ctrl && open_ok;
  assign tov_wr  = wr_en && hit_tov && open_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode32   <= 1'b0;
      en       <= 1'b1;
      upd      <= 1'b1;
      unlocked <= 1'b0;
      done     <= 1'b0;
      win      <= '0;
    end else if (unlock_p) begin
      unlocked <= 1'b1;
      done     <= 1'b0;
      win      <= WIN_FULL;
    end else if (ctrl_wr) begin
      mode32   <= wdata[BIT_MODE32];
      en       <= wdata[BIT_EN];
      upd      <= wdata[BIT_UPD];
      unlocked <= 1'b0;
      done     <= 1'b1;
      win      <= '0;
    end else if (unlocked) begin
      if (win == WIN_W'(1)) begin
        unlocked <= 1'b0;
        win      <= '0;
      end else begin
        win <= win - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         tov <= '1;
    else if (tov_wr) tov <= wdata[TOV_W-1:0];
  end

  AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && wr_en && hit_ctrl) |=> $stable({mode32, en, upd})); // R6
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (win != '0 && win <= WIN_FULL)); // R6
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !unlocked); // R7
  AST_UPD_STICKY: assert property (@(posedge clk) disable iff (rst)
    !upd |=> (!upd && $stable(tov))); // R8
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
  parameter int TOV_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             clear,
  input  logic [TOV_W-1:0] tov,
  output logic [TOV_W-1:0] count,
  output logic             rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!en || clear) begin
        count <= '0;
      end else if (tick) begin
        if (count >= tov) begin
          count   <= '0;
          rst_req <= 1'b1;
        end else begin
          count <= count + TOV_W'(1);
        end
      end
    end
  end

  AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(en) && $past(tick))); // R10
  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> !rst_req); // R11
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int TOV_W      = 17,
  parameter int UNLOCK_CYC = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic              rst_req
);
  logic hit_ctrl, hit_cnt, hit_tov;
  logic unlock_p, refresh_p, ctrl_wr;
  logic mode32, en, upd, unlocked, done;
  logic [TOV_W-1:0] tov, count;
  logic [31:0] ctrl_word, rd_mux;

  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign hit_cnt  = (addr == ADDR_W'(OFF_CNT));
  assign hit_tov  = (addr == ADDR_W'(OFF_TOV));

  keyed_wdog_keys u_keys (
    .clk(clk), .rst(rst), .mode32(mode32), .wr_en(wr_en), .wr_full(wr_full),
    .hit_cnt(hit_cnt), .wdata(wdata), .unlock_p(unlock_p), .refresh_p(refresh_p)
  );

  keyed_wdog_cfg #(.TOV_W(TOV_W), .UNLOCK_CYC(UNLOCK_CYC)) u_cfg (
    .clk(clk), .rst(rst), .unlock_p(unlock_p), .wr_en(wr_en),
    .hit_ctrl(hit_ctrl), .hit_tov(hit_tov), .wdata(wdata),
    .mode32(mode32), .en(en), .upd(upd), .unlocked(unlocked), .done(done),
    .tov(tov), .ctrl_wr(ctrl_wr)
  );

  keyed_wdog_cnt #(.TOV_W(TOV_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .en(en),
    .clear(refresh_p || ctrl_wr), .tov(tov), .count(count), .rst_req(rst_req)
  );

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[BIT_MODE32] = mode32;
    ctrl_word[BIT_UNLKD]  = unlocked;
    ctrl_word[BIT_DONE]   = done;
    ctrl_word[BIT_EN]     = en;
    ctrl_word[BIT_UPD]    = upd;
  end

  always_comb begin
    if (hit_ctrl)     rd_mux = ctrl_word;
    else if (hit_cnt) rd_mux = 32'(count);
    else if (hit_tov) rd_mux = 32'(tov);
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0, wr_full = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic rst_req;
  int checks = 0, errors = 0, cyc = 0, pulses;
  logic [31:0] v;

  always #2 clk = ~clk;

  keyed_wdog u_dut (.clk(clk), .rst(rst), .tick_en(tick_en), .addr(addr),
    .wr_en(wr_en), .wr_full(wr_full), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .rst_req(rst_req));

  // behavioural model
  int m_seq, m_win, m_tov, m_cnt;
  bit m_m32, m_en, m_upd, m_unl, m_done, m_fire;
  always @(posedge clk) begin
    if (rst) begin
      m_seq = 0; m_win = 0; m_tov = 'h1FFFF; m_cnt = 0;
      m_m32 = 0; m_en = 1; m_upd = 1; m_unl = 0; m_done = 0; m_fire = 0;
    end else begin
      bit wc, unl, rf, cw, tw, en0;
      wc = wr_en && addr == 4; unl = 0; rf = 0;
      if (m_m32) begin
        unl = wc && wr_full && wdata == 32'hD928C520;
        rf  = wc && wr_full && wdata == 32'hB480A602;
        m_seq = 0;
      end else begin
        unl = wc && !wr_full && m_seq == 1 && wdata[15:0] == 16'hD928;
        rf  = wc && !wr_full && m_seq == 2 && wdata[15:0] == 16'hB480;
        if (wr_en) m_seq = (wc && !wr_full && wdata[15:0] == 16'hC520) ? 1 :
                           (wc && !wr_full && wdata[15:0] == 16'hA602) ? 2 : 0;
      end
      cw = wr_en && addr == 0 && m_unl && m_upd;
      tw = wr_en && addr == 8 && m_unl && m_upd;
      en0 = m_en;
      if (tw) m_tov = wdata[16:0];
      if (unl) begin m_unl = 1; m_win = 128; m_done = 0; end
      else if (cw) begin
        m_m32 = wdata[13]; m_en = wdata[7]; m_upd = wdata[5];
        m_unl = 0; m_done = 1;
      end else if (m_unl) begin
        if (m_win == 1) m_unl = 0; else m_win--;
      end
      m_fire = 0;
      if (!en0 || rf || cw) m_cnt = 0;
      else if (tick_en) begin
        if (m_cnt >= m_tov) begin m_cnt = 0; m_fire = 1; end
        else m_cnt++;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) chk(32'(rst_req), 32'(m_fire), "R10 model rst_req");
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic full);
    addr = a; wdata = d; wr_full = full; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (rst_req) pulses++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R2 offsets and bit positions
    chk(32'(rst_req), 0, "R1 rst_req");
    rd(4'h0, v); chk(v, 32'h0000_00A0, "R1 R2 ctrl");
    rd(4'h8, v); chk(v, 32'h0001_FFFF, "R1 tov");
    rd(4'h4, v); chk(v, 0, "R1 count");
    // R6 locked write ignored
    wr(4'h8, 32'h10, 1'b1);
    rd(4'h8, v); chk(v, 32'h1FFFF, "R6 locked tov");
    // R5 other value to counter
    wr(4'h4, 32'h1234, 1'b0);
    rd(4'h0, v); chk(v, 32'hA0, "R5 lock state");
    // R4 broken pair
    wr(4'h4, 32'hC520, 1'b0); wr(4'h0, 32'h0, 1'b1); wr(4'h4, 32'hD928, 1'b0);
    rd(4'h0, v); chk(v, 32'hA0, "R4 broken pair");
    // R3 32-bit key ignored in 16-bit mode
    wr(4'h4, 32'hD928C520, 1'b1);
    rd(4'h0, v); chk(v, 32'hA0, "R3 wrong mode");
    // R4 proper pair
    wr(4'h4, 32'hC520, 1'b0); wr(4'h4, 32'hD928, 1'b0);
    rd(4'h0, v); chk(v, 32'h8A0, "R4 unlocked");
    // R7 tov write keeps window open, ctrl write closes it
    wr(4'h8, 32'h6, 1'b1);
    rd(4'h8, v); chk(v, 6, "R7 tov written");
    rd(4'h0, v); chk(v, 32'h8A0, "R7 still open");
    wr(4'h0, 32'h20A0, 1'b1);
    rd(4'h0, v); chk(v, 32'h24A0, "R7 done set");
    // R9 count advances
    pulses = 0;
    ticks(3);
    rd(4'h4, v); chk(v, 3, "R9 count");
    // R11 refresh
    wr(4'h4, 32'hB480A602, 1'b1);
    rd(4'h4, v); chk(v, 0, "R11 refresh clears");
    // R10 expiry pulses
    pulses = 0; ticks(14); chk(32'(pulses), 2, "R10 pulse count");
    // R11 refresh and expiring tick in the same cycle
    pulses = 0; ticks(6);
    addr = 4'h4; wdata = 32'hB480A602; wr_full = 1'b1; wr_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    chk(32'(rst_req), 0, "R11 refresh wins");
    chk(32'(pulses), 0, "R11 no early fire");
    rd(4'h4, v); chk(v, 0, "R11 count after collision");
    // R3 16-bit refresh ignored in 32-bit mode; R5 stray value
    ticks(2);
    wr(4'h4, 32'hA602, 1'b0); wr(4'h4, 32'hB480, 1'b0);
    rd(4'h4, v); chk(v, 2, "R3 16-bit ignored");
    wr(4'h4, 32'h12345678, 1'b1);
    rd(4'h4, v); chk(v, 2, "R5 count kept");
    rd(4'h0, v); chk(v, 32'h24A0, "R5 lock kept");
    // R9 disabled
    wr(4'h4, 32'hD928C520, 1'b1); wr(4'h0, 32'h2020, 1'b1);
    pulses = 0; ticks(10);
    rd(4'h4, v); chk(v, 0, "R9 disabled count");
    chk(32'(pulses), 0, "R9 disabled no fire");
    wr(4'h4, 32'hD928C520, 1'b1);
    rd(4'h0, v); chk(v, 32'h2820, "R7 unlock clears done");
    // R12 full-range timeout
    wr(4'h8, 32'd128000, 1'b1);
    rd(4'h8, v); chk(v, 32'd128000, "R12 tov 128 s");
    wr(4'h8, 32'h6, 1'b1); wr(4'h0, 32'h20A0, 1'b1);
    // R6 last edge of the window accepted
    wr(4'h4, 32'hD928C520, 1'b1); idle(127); wr(4'h8, 32'h7, 1'b1);
    rd(4'h8, v); chk(v, 7, "R6 last edge");
    // R6 one edge beyond the window ignored
    wr(4'h4, 32'hD928C520, 1'b1); idle(128); wr(4'h8, 32'h9, 1'b1);
    rd(4'h8, v); chk(v, 7, "R6 expired window");
    rd(4'h0, v); chk(v, 32'h20A0, "R6 closed");
    // R8 update lock
    wr(4'h4, 32'hD928C520, 1'b1); wr(4'h0, 32'h2080, 1'b1);
    rd(4'h0, v); chk(v, 32'h2480, "R8 upd cleared");
    wr(4'h4, 32'hD928C520, 1'b1); wr(4'h8, 32'h9, 1'b1); wr(4'h0, 32'h20A0, 1'b1);
    rd(4'h8, v); chk(v, 7, "R8 tov frozen");
    rd(4'h0, v); chk(v, 32'h2880, "R8 ctrl frozen");
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule